// File: doc/BRIEF.md
# Time-Domain Race Binary Neuron

This block is a cycle-level model of a binary neuron that decides by a race in time rather than by a weighted sum. Two charge accumulators stand for two dynamic nodes, one excitatory and one inhibitory. Both start each evaluation window at a full value. On every evaluation tick each accumulator loses the summed conductance of the synapses whose presynaptic bit is 1. The first accumulator to drop below a threshold fires. The arbiter then recharges the other accumulator, so that its flag stays low.

A signed weight per synapse sets two conductances. A positive weight raises the excitatory conductance along a linear scale above a floor value, and the inhibitory conductance stays at that floor. A negative weight does the same for the inhibitory side. A phase input selects precharge or evaluation, and a window-length input caps the number of evaluation ticks. The block is meant to be placed in layers. Each layer holds its inputs steady for the whole window, and the next layer evaluates only once this window has ended.

Top module: `race_neuron`

## Requirements
- R1: While `precharge` is 1 at a clock edge, both accumulators return to full charge and both fire flags read 0 after that edge. An active-low reset has the same effect.
- R2: During evaluation a synapse adds its conductance to a path's per-tick discharge only while its bit in `preBits` is 1. With all bits at 0, neither flag ever sets.
- R3: A weight w > 0 gives the excitatory conductance G_MIN + floor((G_MAX-G_MIN)*w/M) and the inhibitory conductance G_MIN, where M = 2^(WEIGHT_W-1)-1. Weights are two's complement, and synapse i uses bits [i*WEIGHT_W +: WEIGHT_W] of `weights`. A weight of 0 gives G_MIN on both sides.
- R4: A weight w < 0 gives the inhibitory conductance G_MIN + floor((G_MAX-G_MIN)*min(|w|,M)/M) and the excitatory conductance G_MIN. The most negative code therefore maps to G_MAX.
- R5: Let r be a path's discharge per tick. The path crosses on evaluation tick n = floor((FULL_CHARGE-THRESHOLD)/r)+1, where tick 1 is the first clock edge with `precharge` at 0. Its flag reads 1 after that edge and stays 1 until the next precharge.
- R6: Once one path has fired, the other flag stays 0 for the rest of the window. The two flags are never 1 together.
- R7: If both paths cross on the same tick, the excitatory flag sets.
- R8: Only the first `winLen` evaluation ticks can discharge. If neither crossing tick is at or below `winLen`, both flags stay 0 until the next precharge. A `winLen` of 0 never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one evaluation tick per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| precharge | input | 1 | 1 = precharge phase, 0 = evaluation phase |
| preBits | input | NUM_SYN | Presynaptic binary inputs, held for the window |
| weights | input | NUM_SYN*WEIGHT_W | Packed signed weights, synapse i at bits [i*WEIGHT_W +: WEIGHT_W] |
| winLen | input | WIN_W | Number of evaluation ticks in the window |
| excFire | output | 1 | Excitatory path won the race |
| inhFire | output | 1 | Inhibitory path won the race |

## Verification
The bench uses the default build: four synapses, 4-bit weights, and conductances from 1 to 15. With these values a conductance is 1+2|w|. The charge runs from 255 down to a threshold of 128, which leaves a margin of 127. In this build the crossing tick of every input pattern can be worked out by hand. The vectors include an exact tie at tick 32, windows one tick short of a crossing and exactly at a crossing, and the clamped most-negative weight. The window input is 8 bits wide, so windows longer than any possible crossing time are also covered.

// File: rtl/race_pkg.sv
package race_pkg;

  typedef enum logic [1:0] {
    PH_PRE  = 2'd0,
    PH_EVAL = 2'd1,
    PH_DONE = 2'd2
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic reload;   // restore both nodes to full charge
    logic step;     // apply one discharge tick
    logic clrExc;   // recharge excitatory node (it lost)
    logic clrInh;   // recharge inhibitory node (it lost)
  } ctrlStrobes_t;

  // Linear weight-to-conductance scaling for one side of a synapse
  function automatic int condScale(input int w, input int maxMag,
                                   input int gMin, input int gMax,
                                   input bit excSide);
    int mag;
    mag = (w < 0) ? -w : w;
    if (mag > maxMag) mag = maxMag;
    if (excSide ? (w > 0) : (w < 0))
      return gMin + ((gMax - gMin) * mag) / maxMag;
    return gMin;
  endfunction

endpackage

// File: rtl/race_datapath.sv
module race_datapath
  import race_pkg::*;
#(
  parameter int NUM_SYN     = 4,
  parameter int WEIGHT_W    = 4,
  parameter int G_MIN       = 1,
  parameter int G_MAX       = 15,
  parameter int CHARGE_W    = 8,
  parameter int FULL_CHARGE = 255,
  parameter int THRESHOLD   = 128
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_SYN-1:0]          preBits,
  input  logic [NUM_SYN*WEIGHT_W-1:0] weights,
  input  ctrlStrobes_t                stb,
  output logic                        excCross,
  output logic                        inhCross
);

  localparam int MAX_MAG = (1 << (WEIGHT_W - 1)) - 1;
  localparam int G_W     = $clog2(G_MAX + 1);
  localparam int RATE_W  = $clog2(NUM_SYN * G_MAX + 1);
  localparam int DW      = (CHARGE_W > RATE_W) ? CHARGE_W : RATE_W;
  localparam logic [CHARGE_W-1:0] FULL = CHARGE_W'(FULL_CHARGE);
  localparam logic [CHARGE_W-1:0] THR  = CHARGE_W'(THRESHOLD);

  logic [G_W-1:0]      gExc [NUM_SYN];
  logic [G_W-1:0]      gInh [NUM_SYN];
  logic [RATE_W-1:0]   excRate, inhRate;
  logic [CHARGE_W-1:0] excNode, inhNode;
  logic [CHARGE_W-1:0] excNext, inhNext;
  logic [DW-1:0]       excNextW, inhNextW;

  // Per-synapse conductance pair
  for (genvar i = 0; i < NUM_SYN; i++) begin : g_syn
    logic signed [WEIGHT_W-1:0] wS;
    assign wS      = weights[i*WEIGHT_W +: WEIGHT_W];
    assign gExc[i] = G_W'(condScale(int'(wS), MAX_MAG, G_MIN, G_MAX, 1'b1));
    assign gInh[i] = G_W'(condScale(int'(wS), MAX_MAG, G_MIN, G_MAX, 1'b0));
  end

  // Only synapses with an active input join the discharge
  always_comb begin
    excRate = '0;
    inhRate = '0;
    for (int i = 0; i < NUM_SYN; i++) begin
      if (preBits[i]) begin
        excRate = excRate + RATE_W'(gExc[i]);
        inhRate = inhRate + RATE_W'(gInh[i]);
      end
    end
  end

  // Saturating discharge
  always_comb begin
    excNextW = (DW'(excNode) > DW'(excRate)) ? DW'(excNode) - DW'(excRate) : '0;
    inhNextW = (DW'(inhNode) > DW'(inhRate)) ? DW'(inhNode) - DW'(inhRate) : '0;
    excNext  = CHARGE_W'(excNextW);
    inhNext  = CHARGE_W'(inhNextW);
  end

  assign excCross = (excNext < THR);
  assign inhCross = (inhNext < THR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excNode <= FULL;
      inhNode <= FULL;
    end else if (stb.reload) begin
      excNode <= FULL;
      inhNode <= FULL;
    end else if (stb.step) begin
      excNode <= stb.clrExc ? FULL : excNext;
      inhNode <= stb.clrInh ? FULL : inhNext;
    end
  end

  // R1: reload strobe restores both nodes
  a_r1_reload_full: assert property (@(posedge clk) disable iff (!rstN)
    stb.reload |=> (excNode == FULL && inhNode == FULL));

  // R6: the losing node is recharged
  a_r6_loser_full: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && stb.clrInh && !stb.reload) |=> (inhNode == FULL));

  // R2: discharge never adds charge
  a_r2_no_gain: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !stb.clrExc && !stb.reload) |=> (excNode <= $past(excNode)));

endmodule

// File: rtl/race_control.sv
module race_control
  import race_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             precharge,
  input  logic [WIN_W-1:0] winLen,
  input  logic             excCross,
  input  logic             inhCross,
  output ctrlStrobes_t     stb,
  output logic             excFire,
  output logic             inhFire
);

  phase_t           phase;
  logic [WIN_W-1:0] tickCnt;
  logic             inWindow;

  assign inWindow = (phase != PH_DONE) && (tickCnt < winLen);

  always_comb begin
    stb = '0;
    if (precharge) begin
      stb.reload = 1'b1;
    end else if (inWindow) begin
      stb.step = 1'b1;
      if (excCross)      stb.clrInh = 1'b1;   // tie goes to excitatory
      else if (inhCross) stb.clrExc = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_PRE;
      tickCnt <= '0;
      excFire <= 1'b0;
      inhFire <= 1'b0;
    end else if (precharge) begin
      phase   <= PH_PRE;
      tickCnt <= '0;
      excFire <= 1'b0;
      inhFire <= 1'b0;
    end else if (phase != PH_DONE) begin
      if (inWindow) begin
        tickCnt <= tickCnt + 1'b1;
        if (excCross) begin
          excFire <= 1'b1;
          phase   <= PH_DONE;
        end else if (inhCross) begin
          inhFire <= 1'b1;
          phase   <= PH_DONE;
        end else begin
          phase   <= PH_EVAL;
        end
      end else begin
        phase <= PH_DONE;
      end
    end
  end

  // R1: precharge silences both flags
  a_r1_quiet_precharge: assert property (@(posedge clk) disable iff (!rstN)
    precharge |=> (!excFire && !inhFire));

  // R6: flags are mutually exclusive
  a_r6_one_winner: assert property (@(posedge clk) disable iff (!rstN)
    !(excFire && inhFire));

  // R5: a fired flag holds until precharge
  a_r5_exc_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (excFire && !precharge) |=> excFire);

  a_r5_inh_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (inhFire && !precharge) |=> inhFire);

  // R8: once finished, no further ticks are taken
  a_r8_frozen_done: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DONE && !precharge) |=> $stable(tickCnt));

endmodule

// File: rtl/race_neuron.sv
module race_neuron
  import race_pkg::*;
#(
  parameter int NUM_SYN     = 4,
  parameter int WEIGHT_W    = 4,
  parameter int G_MIN       = 1,
  parameter int G_MAX       = 15,
  parameter int CHARGE_W    = 8,
  parameter int FULL_CHARGE = 255,
  parameter int THRESHOLD   = 128,
  parameter int WIN_W       = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        precharge,
  input  logic [NUM_SYN-1:0]          preBits,
  input  logic [NUM_SYN*WEIGHT_W-1:0] weights,
  input  logic [WIN_W-1:0]            winLen,
  output logic                        excFire,
  output logic                        inhFire
);

  ctrlStrobes_t stb;
  logic         excCross, inhCross;

  race_datapath #(
    .NUM_SYN(NUM_SYN), .WEIGHT_W(WEIGHT_W), .G_MIN(G_MIN), .G_MAX(G_MAX),
    .CHARGE_W(CHARGE_W), .FULL_CHARGE(FULL_CHARGE), .THRESHOLD(THRESHOLD)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .preBits(preBits), .weights(weights),
    .stb(stb), .excCross(excCross), .inhCross(inhCross)
  );

  race_control #(
    .WIN_W(WIN_W)
  ) i_control (
    .clk(clk), .rstN(rstN), .precharge(precharge), .winLen(winLen),
    .excCross(excCross), .inhCross(inhCross), .stb(stb),
    .excFire(excFire), .inhFire(inhFire)
  );

endmodule

// File: tb/test_race_neuron.sv
module test_race_neuron;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        precharge = 1'b1;
  logic [3:0]  preBits = '0;
  logic [15:0] weights = '0;
  logic [7:0]  winLen = '0;
  logic        excFire, inhFire;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  race_neuron i_race_neuron (
    .clk(clk), .rstN(rstN), .precharge(precharge), .preBits(preBits),
    .weights(weights), .winLen(winLen), .excFire(excFire), .inhFire(inhFire)
  );

  typedef struct packed {
    logic [3:0]  bits;
    logic [15:0] w;
    logic [7:0]  win;
    logic        expExc;
    logic        expInh;
    logic [7:0]  expTick;
  } vec_t;

  // Conductance 1+2|w|, margin 127, tick n = floor(127/r)+1
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'b1111, 16'h7777, 8'd10,  1'b1, 1'b0, 8'd3},   // R3 exc r=60 inh r=4
    '{4'b0001, 16'h777D, 8'd40,  1'b0, 1'b1, 8'd19},  // R4 w=-3: inh r=7
    '{4'b1111, 16'h0000, 8'd40,  1'b1, 1'b0, 8'd32},  // R7 tie r=4 both
    '{4'b1111, 16'h0000, 8'd31,  1'b0, 1'b0, 8'd0},   // R8 window one short
    '{4'b0000, 16'h7777, 8'd255, 1'b0, 1'b0, 8'd0},   // R2 no active inputs
    '{4'b0011, 16'h0085, 8'd20,  1'b0, 1'b1, 8'd8},   // R4 clamp -8: exc 12 inh 16
    '{4'b1010, 16'h7070, 8'd5,   1'b1, 1'b0, 8'd5},   // R8 window exactly at crossing
    '{4'b1010, 16'h7070, 8'd4,   1'b0, 1'b0, 8'd0}    // R8 window one short
  };

  task automatic check(input logic actE, input logic actI,
                       input logic expE, input logic expI, input string tag);
    checks++;
    if (actE !== expE || actI !== expI) begin
      fails++;
      $display("FAIL %s: exc/inh actual %b%b expected %b%b at %0t",
               tag, actE, actI, expE, expI, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    @(negedge clk);
    precharge = 1'b1;
    preBits   = v.bits;
    weights   = v.w;
    winLen    = v.win;
    @(negedge clk);
    @(negedge clk);
    check(excFire, inhFire, 1'b0, 1'b0, "R1 precharge quiet");
    precharge = 1'b0;
    for (int t = 1; t <= int'(v.win) + 2; t++) begin
      @(negedge clk);
      check(excFire, inhFire,
            v.expExc && (t >= int'(v.expTick)),
            v.expInh && (t >= int'(v.expTick)),
            $sformatf("R2 R3 R4 R5 R6 R7 R8 vec %0d tick %0d", idx, t));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    #2;
    check(excFire, inhFire, 1'b0, 1'b0, "R1 in reset");
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(excFire, inhFire, 1'b0, 1'b0, "R1 after reset");

    for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

    // R8: zero-length window never fires
    run_vec('{4'b1111, 16'h7777, 8'd0, 1'b0, 1'b0, 8'd0}, 100);

    // R1: precharge clears a fired flag on the next edge
    @(negedge clk);
    precharge = 1'b1; preBits = 4'b1111; weights = 16'h7777; winLen = 8'd10;
    @(negedge clk);
    precharge = 1'b0;
    repeat (4) @(negedge clk);
    check(excFire, inhFire, 1'b1, 1'b0, "R5 fired before precharge");
    precharge = 1'b1;
    @(negedge clk);
    check(excFire, inhFire, 1'b0, 1'b0, "R1 precharge clears flag");

    // R1: reset mid-window clears flags and nodes
    precharge = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    #1;
    check(excFire, inhFire, 1'b0, 1'b0, "R1 async reset");
    @(negedge clk);
    rstN = 1'b1;
    precharge = 1'b1;
    @(negedge clk);
    precharge = 1'b0;
    repeat (2) @(negedge clk);
    check(excFire, inhFire, 1'b0, 1'b0, "R5 no fire before tick 3 after reset");
    @(negedge clk);
    check(excFire, inhFire, 1'b1, 1'b0, "R5 fire at tick 3 after reset");

    finish_run();
  end

endmodule